// File: doc/BRIEF.md
# Parallel XOR Storage Array with Toggle and Erase

This block is a small storage array, built from flip-flops, that can also compute on its own contents. Outside a command it behaves as an ordinary word memory: one row per address, a one-cycle write and a read whose data appears on the next cycle. On a command it combines every row with a column operand vector in a single operation.

An XOR command runs two ordered phases on every row at the same time. The reset phase keeps a copy of each cell and clears the cells in the columns where the operand bit is 1. The flip phase then sets each of those cells to the inverse of its kept copy. A toggle command is an XOR with the operand forced to all ones, so it inverts the whole array. An erase command runs the reset phase alone with every column selected, which clears the whole array.

A start strobe launches a command. Busy stays high until done pulses. Normal accesses are ignored while busy is high. A command issued while busy is high, or an undefined command code, is dropped and sets a sticky error flag.

Top module: `xor_toggle_array`

## Requirements
- R1: When busy is low, a write with `wrEn` stores `wrData` in row `addr`. A read with `rdEn` puts row `addr` on `rdData` after the next clock edge. `rdData` otherwise holds its value.
- R2: After reset every cell is 0, and `rdData`, `busy`, `done` and `cmdErr` are all 0.
- R3: Command code 0 (XOR) replaces every row with row XOR operand in one operation. The operand is the value of `operand` sampled at the start edge.
- R4: An XOR with an all-zero operand leaves every row unchanged.
- R5: Command code 1 (toggle) inverts every cell of the array, whatever the value on `operand`.
- R6: Command code 2 (erase) clears every cell. `done` is high in the second cycle after the start edge.
- R7: After an accepted start, `busy` is high from the next cycle through the `done` cycle. For XOR and toggle, `done` is high in the third cycle after the start edge. `done` is a single-cycle pulse.
- R8: While `busy` is high, reads and writes have no effect: the array is not changed and `rdData` holds its value.
- R9: A start while `busy` is high is dropped. It sets `cmdErr`, which stays set until reset.
- R10: Command code 3 is undefined. A start with code 3 does not raise busy, changes nothing in the array, and sets `cmdErr`.
- R11: Changes on `operand` after the start edge do not affect the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | AW | Row address for read and write |
| wrEn | input | 1 | Write request |
| wrData | input | COLS | Write data |
| rdEn | input | 1 | Read request |
| rdData | output | COLS | Registered read data |
| operand | input | COLS | Column operand vector |
| cmd | input | 2 | Command code: 0 XOR, 1 toggle, 2 erase, 3 undefined |
| start | input | 1 | Command strobe |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| cmdErr | output | 1 | Sticky flag for a dropped command |

## Verification
The XOR runs over rows that hold different values, with a mixed operand such as A5. A wrong column mask or a row that is missed then shows in the readback. An all-zero operand tells a correct flip phase apart from one that rewrites cells without regard to the mask. The toggle command is issued with a zero operand on the input, which shows that the forced all-ones mask is used instead. The operand is also changed in the middle of a command, which shows whether the design samples it at the start edge or reads it live.

// File: rtl/xta_pkg.sv
package xta_pkg;
  typedef enum logic [1:0] {
    CMD_XOR    = 2'd0,
    CMD_TOGGLE = 2'd1,
    CMD_ERASE  = 2'd2,
    CMD_BAD    = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RESET = 2'd1,
    ST_FLIP  = 2'd2,
    ST_FIN   = 2'd3
  } state_e;

  // Strobes from the sequencer to the array datapath
  typedef struct packed {
    logic busy;
    logic resetPh;
    logic flipPh;
    logic clearAll;
  } ctlStrobes_t;
endpackage

// File: rtl/xta_ctrl.sv
module xta_ctrl
  import xta_pkg::*;
#(
  parameter int COLS = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [1:0]      cmd,
  input  logic [COLS-1:0] operand,
  output ctlStrobes_t     strobes,
  output logic [COLS-1:0] opMask,
  output logic            busy,
  output logic            done,
  output logic            cmdErr
);
  state_e state;
  logic   isErase;
  cmd_e   cmdIn;

  assign cmdIn = cmd_e'(cmd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      isErase <= 1'b0;
      opMask  <= '0;
      cmdErr  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (cmdIn == CMD_BAD) begin
              cmdErr <= 1'b1;
            end else begin
              state   <= ST_RESET;
              isErase <= (cmdIn == CMD_ERASE);
              opMask  <= (cmdIn == CMD_XOR) ? operand : '1;
            end
          end
        end
        ST_RESET: state <= isErase ? ST_FIN : ST_FLIP;
        ST_FLIP:  state <= ST_FIN;
        default:  state <= ST_IDLE;
      endcase
      if (start && state != ST_IDLE) cmdErr <= 1'b1;
    end
  end

  assign busy             = (state != ST_IDLE);
  assign done             = (state == ST_FIN);
  assign strobes.busy     = busy;
  assign strobes.resetPh  = (state == ST_RESET);
  assign strobes.flipPh   = (state == ST_FLIP);
  assign strobes.clearAll = isErase;

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R7
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && cmd != CMD_BAD) |=> busy);
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdErr |=> cmdErr);
  // R10
  bad_cmd_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && cmd == CMD_BAD) |=> (!busy && cmdErr));
  // R11
  mask_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> $stable(opMask));
endmodule

// File: rtl/xta_array.sv
module xta_array
  import xta_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int AW   = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrobes_t     strobes,
  input  logic [COLS-1:0] opMask,
  input  logic [AW-1:0]   addr,
  input  logic            wrEn,
  input  logic [COLS-1:0] wrData,
  input  logic            rdEn,
  output logic [COLS-1:0] rdData
);
  logic [ROWS-1:0][COLS-1:0] cells;
  logic [ROWS-1:0][COLS-1:0] sample;
  logic                      wrAcc;
  logic                      rdAcc;

  assign wrAcc = wrEn && !strobes.busy;
  assign rdAcc = rdEn && !strobes.busy && (int'(addr) < ROWS);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cells[r]  <= '0;
        sample[r] <= '0;
      end else if (strobes.resetPh) begin
        sample[r] <= cells[r];
        cells[r]  <= strobes.clearAll ? '0 : (cells[r] & ~opMask);
      end else if (strobes.flipPh) begin
        cells[r] <= (cells[r] & ~opMask) | (~sample[r] & opMask);
      end else if (wrAcc && int'(addr) == r) begin
        cells[r] <= wrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      rdData <= '0;
    else if (rdAcc) rdData <= cells[addr];
  end

  // R3
  flip_in_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flipPh |=> (((cells ^ $past(cells)) & ~{ROWS{opMask}}) == '0));
  // R6
  erase_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.resetPh && strobes.clearAll) |=> (cells == '0));
  // R8
  busy_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.busy && !strobes.resetPh && !strobes.flipPh) |=> $stable(cells));
  // R8
  busy_rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.busy |=> $stable(rdData));
endmodule

// File: rtl/xor_toggle_array.sv
module xor_toggle_array
  import xta_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int AW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [AW-1:0]   addr,
  input  logic            wrEn,
  input  logic [COLS-1:0] wrData,
  input  logic            rdEn,
  output logic [COLS-1:0] rdData,
  input  logic [COLS-1:0] operand,
  input  logic [1:0]      cmd,
  input  logic            start,
  output logic            busy,
  output logic            done,
  output logic            cmdErr
);
  ctlStrobes_t     strobes;
  logic [COLS-1:0] opMask;

  xta_ctrl #(.COLS(COLS)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cmd(cmd), .operand(operand),
    .strobes(strobes), .opMask(opMask), .busy(busy), .done(done),
    .cmdErr(cmdErr)
  );

  xta_array #(.ROWS(ROWS), .COLS(COLS), .AW(AW)) u_array (
    .clk(clk), .rstN(rstN), .strobes(strobes), .opMask(opMask),
    .addr(addr), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData)
  );
endmodule

// File: tb/xor_toggle_array_test.sv
`timescale 1ns/1ps
module xor_toggle_array_test;
  localparam int ROWS = 8;
  localparam int COLS = 8;
  localparam int AW   = 3;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic            wrEn = 1'b0;
  logic [COLS-1:0] wrData = '0;
  logic            rdEn = 1'b0;
  logic [COLS-1:0] rdData;
  logic [COLS-1:0] operand = '0;
  logic [1:0]      cmd = 2'd0;
  logic            start = 1'b0;
  logic            busy, done, cmdErr;

  int    testsRun = 0;
  int    testsFailed = 0;
  int    cycles = 0;
  string curTag = "R1";

  xor_toggle_array #(.ROWS(ROWS), .COLS(COLS)) uut (.*);

  always #10 clk = ~clk;

  // Behavioural reference: array contents, phase counter, expected outputs
  logic [COLS-1:0] mMem [ROWS];
  logic [COLS-1:0] mOp;
  logic [COLS-1:0] mRd;
  int              mPhase;
  bit              mErase;
  bit              mErr;

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      for (int i = 0; i < ROWS; i++) mMem[i] = '0;
      mRd = '0; mPhase = 0; mErr = 0; mErase = 0; mOp = '0;
    end else if (mPhase == 0) begin
      if (wrEn) mMem[addr] = wrData;
      if (rdEn) mRd = mMem[addr];
      if (start) begin
        if (cmd == 2'd3) mErr = 1;
        else begin
          mPhase = 1;
          mErase = (cmd == 2'd2);
          mOp = (cmd == 2'd0) ? operand : '1;
        end
      end
    end else begin
      if (start) mErr = 1;
      if (mPhase == 3) mPhase = 0;
      else if (mPhase == 1 && !mErase) mPhase = 2;
      else begin
        mPhase = 3;
        for (int i = 0; i < ROWS; i++)
          mMem[i] = mErase ? '0 : (mMem[i] ^ mOp);
      end
    end
  end

  task automatic checkEq(string tag, longint act, longint exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && cycles > 0) begin
      checkEq(curTag, rdData, mRd);
      checkEq("R7 busy", busy, mPhase != 0);
      checkEq("R7 done", done, mPhase == 3);
      checkEq("R9 cmdErr", cmdErr, mErr);
    end
  end

  task automatic idle();
    @(negedge clk);
    wrEn = 0; rdEn = 0; start = 0;
  endtask

  task automatic writeRow(int r, logic [COLS-1:0] d);
    @(negedge clk);
    addr = AW'(r); wrData = d; wrEn = 1; rdEn = 0; start = 0;
  endtask

  task automatic readAll(string tag);
    curTag = tag;
    for (int r = 0; r < ROWS; r++) begin
      @(negedge clk);
      addr = AW'(r); rdEn = 1; wrEn = 0; start = 0;
    end
    idle();
    idle();
  endtask

  task automatic issue(logic [1:0] c, logic [COLS-1:0] op);
    @(negedge clk);
    cmd = c; operand = op; start = 1; wrEn = 0; rdEn = 0;
    @(negedge clk);
    start = 0;
  endtask

  task automatic waitIdle();
    for (int k = 0; k < 6; k++) idle();
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R2: reset state
    checkEq("R2 rdData", rdData, 0);
    checkEq("R2 busy", busy, 0);
    checkEq("R2 done", done, 0);
    checkEq("R2 cmdErr", cmdErr, 0);
    rstN = 1;
    readAll("R2 cells");

    // R1: plain write/read
    for (int r = 0; r < ROWS; r++) writeRow(r, COLS'(r * 37 + 5));
    idle();
    readAll("R1");

    // R3: parallel XOR with a mixed operand
    issue(2'd0, 8'hA5);
    waitIdle();
    readAll("R3");

    // R4: zero operand leaves array unchanged
    issue(2'd0, 8'h00);
    waitIdle();
    readAll("R4");

    // R5: toggle ignores operand input
    issue(2'd1, 8'h00);
    waitIdle();
    readAll("R5");

    // R11: operand changes after start
    issue(2'd0, 8'h3C);
    operand = 8'hFF;
    idle(); operand = 8'h81;
    waitIdle();
    readAll("R11");

    // R8: reads and writes during busy ignored
    curTag = "R8";
    @(negedge clk);
    cmd = 2'd0; operand = 8'h0F; start = 1;
    @(negedge clk);
    start = 0; wrEn = 1; addr = 3'd2; wrData = 8'hEE; rdEn = 1;
    idle(); wrEn = 1; rdEn = 1; addr = 3'd5; wrData = 8'h11;
    idle(); wrEn = 1; rdEn = 1;
    waitIdle();
    readAll("R8");

    // R10: undefined code rejected
    curTag = "R10";
    issue(2'd3, 8'hFF);
    checkEq("R10 busy", busy, 0);
    checkEq("R10 cmdErr", cmdErr, 1);
    waitIdle();
    readAll("R10");

    // re-reset to clear flag, then R9
    @(negedge clk); rstN = 0;
    @(negedge clk); rstN = 1;
    checkEq("R9 cleared", cmdErr, 0);
    for (int r = 0; r < ROWS; r++) writeRow(r, COLS'(r * 19 + 100));
    idle();
    curTag = "R9";
    @(negedge clk); cmd = 2'd0; operand = 8'h55; start = 1;
    @(negedge clk); cmd = 2'd2; start = 1;
    @(negedge clk); start = 0;
    checkEq("R9 err", cmdErr, 1);
    waitIdle();
    readAll("R9");

    // R6: erase, done in second cycle
    @(negedge clk); cmd = 2'd2; operand = 8'h00; start = 1;
    @(negedge clk); start = 0;
    checkEq("R6 busy", busy, 1);
    checkEq("R6 done early", done, 0);
    @(negedge clk);
    checkEq("R6 done", done, 1);
    waitIdle();
    readAll("R6");

    // R7: XOR done in third cycle
    writeRow(0, 8'h9A);
    @(negedge clk); cmd = 2'd0; operand = 8'hFF; start = 1; wrEn = 0;
    @(negedge clk); start = 0;
    checkEq("R7 c1", done, 0);
    @(negedge clk);
    checkEq("R7 c2", done, 0);
    @(negedge clk);
    checkEq("R7 c3", done, 1);
    waitIdle();
    readAll("R7 R5 all-ones");

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #2000000;
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule